// File: doc/BRIEF.md
# Fail-Safe Clock Monitor with Switchover

This block watches the system clock that is currently selected and falls back to an internal RC oscillator when that clock goes missing. All of its logic runs on a slow, always-running reference clock from the low-power RC oscillator. The monitored clock is treated as an asynchronous data input. It passes through a synchronizer and then an edge detector. A miss counter counts reference cycles that go by without a rising edge. If the count reaches `MISS_LIMIT`, the block takes the select over to the fallback source, sets a sticky failure flag and raises a trap request for software.

Monitoring is armed by a one-cycle start pulse from the reset sequencer. Crystal and PLL sources need time to settle, so for them a guard interval of `GUARD_CYCLES` reference cycles runs before watching begins. Other sources are watched at once. Software can clear a failure. It can also ask for a switch to another source, but such a request is refused while a trap is pending.

The control is a four-state machine:
- **IDLE** waits for the start pulse.
- **GUARD** runs the settle interval.
- **WATCH** counts missing edges.
- **FAILED** holds the fallback and the trap.

Its transitions are:
- `start_slow`: IDLE→GUARD.
- `start_fast`: IDLE→WATCH.
- `guard_done`: GUARD→WATCH.
- `switch_slow`: GUARD or WATCH→GUARD.
- `switch_fast`: GUARD→WATCH, or WATCH→WATCH with the count restarted.
- `miss`: WATCH→FAILED.
- `sw_clear`: FAILED→WATCH.
- `disable`: any state→IDLE.

Top module: `clkmon_failsafe`

## Requirements
- R1: After reset, `clk_sel` equals `RESET_SRC` (default 3'd2), and `fail_flag` and `trap_req` are 0.
- R2: Before a start pulse arrives with `watch_en` high, a dead monitored clock never raises `trap_req`.
- R3: A start or an accepted switch with `src_slow`=1 delays watching by `GUARD_CYCLES` cycles. On a dead clock, `trap_req` then rises at the clock edge `GUARD_CYCLES`+`MISS_LIMIT` edges after the accepting edge. With `src_slow`=0 it rises `MISS_LIMIT` edges after it.
- R4: While watching, a run of `MISS_LIMIT` consecutive reference cycles with no synchronized rising edge sets `clk_sel` to `FALLBACK_SRC` (default 3'd0) and sets `fail_flag` and `trap_req`. A monitored clock with one rising edge every `MISS_LIMIT` reference cycles never fails, and one with a period of `MISS_LIMIT`+1 cycles does fail.
- R5: `fail_flag` and `trap_req` stay set until a `sw_clear` pulse or reset. A clear taken in FAILED returns to watching with a fresh count.
- R6: While `trap_req` is set and `watch_en` is high, `sw_req` leaves `clk_sel` unchanged.
- R7: Otherwise `sw_req` loads `sw_target` into `clk_sel` on the next edge and restarts the guard or the miss count, according to `src_slow`.
- R8: With `watch_en` low, the block never changes `clk_sel` on its own and drives `trap_req` low from the next edge. `fail_flag` keeps its value, and software switches still apply.
- R9: After `watch_en` returns high, watching resumes only after a new start pulse.
- R10: A clock that was running and then stops while being watched is detected as a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock from the low-power RC oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Monitored system clock, asynchronous |
| watch_en | input | 1 | Monitor enable |
| seq_start | input | 1 | One-cycle start pulse from the reset sequencer |
| src_slow | input | 1 | 1 when the source being started is crystal or PLL |
| sw_req | input | 1 | Software switch request pulse |
| sw_target | input | SEL_W | Source code requested by software |
| sw_clear | input | 1 | Software clear of flag and trap |
| clk_sel | output | SEL_W | Active clock-source select |
| fail_flag | output | 1 | Sticky clock-failure flag |
| trap_req | output | 1 | Oscillator-failure trap request |

## Verification
The assertions take for granted that every control input except `mon_clk` is synchronous to `ref_clk`, and that `seq_start`, `sw_req` and `sw_clear` are single-cycle pulses. They also assume `src_slow` describes the source being started or switched to in that same cycle. The bench drives all inputs, including the monitored clock pattern, at the falling edge of the reference clock. It never pulses a start together with a switch or a clear. It varies the monitored clock only between whole periods counted in reference cycles, so the synchronizer sees clean levels.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GUARD  = 2'd1,
        ST_WATCH  = 2'd2,
        ST_FAILED = 2'd3
    } mon_state_e;
endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Synchronizer stages followed by one flop for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/clkmon_guard_timer.sv
module clkmon_guard_timer #(
    parameter int unsigned GUARD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int unsigned CW = $clog2(GUARD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(GUARD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = !restart && (cnt_q == LAST);
endmodule

// File: rtl/clkmon_miss_counter.sv
module clkmon_miss_counter #(
    parameter int unsigned MISS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic edge_seen,
    output logic expire
);
    localparam int unsigned CW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(MISS_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || edge_seen) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expire = !restart && !edge_seen && (cnt_q == LAST);
endmodule

// File: rtl/clkmon_failsafe.sv
module clkmon_failsafe
    import clkmon_pkg::*;
#(
    parameter int unsigned SEL_W        = 3,
    parameter int unsigned MISS_LIMIT   = 4,
    parameter int unsigned GUARD_CYCLES = 8,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter logic [SEL_W-1:0] RESET_SRC    = 3'd2,
    parameter logic [SEL_W-1:0] FALLBACK_SRC = 3'd0
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             mon_clk,
    input  logic             watch_en,
    input  logic             seq_start,
    input  logic             src_slow,
    input  logic             sw_req,
    input  logic [SEL_W-1:0] sw_target,
    input  logic             sw_clear,
    output logic [SEL_W-1:0] clk_sel,
    output logic             fail_flag,
    output logic             trap_req
);
    mon_state_e state_q, state_d;

    logic mon_rise;
    logic guard_restart, guard_done;
    logic miss_restart, miss_expire;
    logic sw_accept, fail_hit;

    clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .async_in (mon_clk),
        .rise     (mon_rise)
    );

    assign guard_restart = (state_q != ST_GUARD) || sw_req || !watch_en;

    clkmon_guard_timer #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .restart (guard_restart),
        .done    (guard_done)
    );

    assign miss_restart = (state_q != ST_WATCH) || sw_req || !watch_en;

    clkmon_miss_counter #(.MISS_LIMIT(MISS_LIMIT)) u_miss (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .restart   (miss_restart),
        .edge_seen (mon_rise),
        .expire    (miss_expire)
    );

    // Switches are refused only while an enabled monitor holds a failure.
    assign sw_accept = sw_req && !(watch_en && (state_q == ST_FAILED));
    assign fail_hit  = watch_en && (state_q == ST_WATCH) && miss_expire;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (!watch_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (seq_start) state_d = src_slow ? ST_GUARD : ST_WATCH;
                end
                ST_GUARD: begin
                    if (sw_req)          state_d = src_slow ? ST_GUARD : ST_WATCH;
                    else if (guard_done) state_d = ST_WATCH;
                end
                ST_WATCH: begin
                    if (sw_req)           state_d = src_slow ? ST_GUARD : ST_WATCH;
                    else if (miss_expire) state_d = ST_FAILED;
                end
                ST_FAILED: begin
                    if (sw_clear) state_d = ST_WATCH;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers.
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sel   <= RESET_SRC;
            fail_flag <= 1'b0;
            trap_req  <= 1'b0;
        end else if (fail_hit) begin
            clk_sel   <= FALLBACK_SRC;
            fail_flag <= 1'b1;
            trap_req  <= 1'b1;
        end else begin
            if (sw_accept) clk_sel <= sw_target;
            if (sw_clear) begin
                fail_flag <= 1'b0;
                trap_req  <= 1'b0;
            end
            if (!watch_en) trap_req <= 1'b0;
        end
    end

    // R2: no failure can be declared from IDLE.
    a_r2_idle_quiet: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !$rose(trap_req));

    // R3: no failure can be declared while the settle interval runs.
    a_r3_guard_quiet: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_GUARD) |=> !$rose(trap_req));

    a_r4_fail_selects_fallback: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(trap_req) |-> (clk_sel == FALLBACK_SRC) && fail_flag);

    a_r5_flag_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (fail_flag && !sw_clear) |=> fail_flag);

    a_r5_trap_needs_flag: assert property (@(posedge ref_clk) disable iff (!rst_n)
        trap_req |-> fail_flag);

    a_r6_refuse_switch: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (trap_req && watch_en && sw_req) |=> $stable(clk_sel));

    a_r8_no_trap_disabled: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !watch_en |=> !trap_req);

    a_r8_sel_hold_disabled: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!watch_en && !sw_req) |=> $stable(clk_sel));
endmodule

// File: tb/test_clkmon_failsafe.sv
`timescale 1ns/1ps
module test_clkmon_failsafe;
    localparam int N = 4;
    localparam int G = 8;
    localparam logic [2:0] RST_SRC = 3'd2;
    localparam logic [2:0] FB_SRC  = 3'd0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_clk = 1'b0;
    logic       watch_en = 1'b0;
    logic       seq_start = 1'b0;
    logic       src_slow = 1'b0;
    logic       sw_req = 1'b0;
    logic [2:0] sw_target = 3'd0;
    logic       sw_clear = 1'b0;
    logic [2:0] clk_sel;
    logic       fail_flag;
    logic       trap_req;

    int total = 0;
    int fails = 0;
    string cur_req = "R1";
    int mon_period = 0;
    int mon_phase = 0;

    // Reference model state.
    int m_st = 0;
    int m_g = 0;
    int m_m = 0;
    logic [2:0] m_sel = RST_SRC;
    bit m_flag = 0;
    bit m_trap = 0;
    bit h0 = 0, h1 = 0, h2 = 0;
    bit m_edge, m_fail, m_acc;

    always #2 clk = ~clk;

    clkmon_failsafe #(
        .SEL_W(3), .MISS_LIMIT(N), .GUARD_CYCLES(G), .SYNC_STAGES(2),
        .RESET_SRC(RST_SRC), .FALLBACK_SRC(FB_SRC)
    ) i_clkmon_failsafe (
        .ref_clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .watch_en(watch_en),
        .seq_start(seq_start), .src_slow(src_slow), .sw_req(sw_req),
        .sw_target(sw_target), .sw_clear(sw_clear), .clk_sel(clk_sel),
        .fail_flag(fail_flag), .trap_req(trap_req)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_g = 0; m_m = 0; m_sel = RST_SRC; m_flag = 0; m_trap = 0;
            h0 = 0; h1 = 0; h2 = 0;
        end else begin
            m_edge = h1 && !h2;
            h2 = h1; h1 = h0; h0 = mon_clk;
            m_fail = 0;
            m_acc = sw_req && !(watch_en && m_st == 3);
            if (!watch_en) m_st = 0;
            else case (m_st)
                0: if (seq_start) begin m_st = src_slow ? 1 : 2; m_g = 0; m_m = 0; end
                1: if (sw_req) begin
                       if (src_slow) m_g = 0; else begin m_st = 2; m_m = 0; end
                   end else if (m_g == G - 1) begin m_st = 2; m_m = 0; end
                   else m_g++;
                2: if (sw_req) begin
                       if (src_slow) begin m_st = 1; m_g = 0; end else m_m = 0;
                   end else if (m_edge) m_m = 0;
                   else if (m_m == N - 1) begin m_st = 3; m_fail = 1; end
                   else m_m++;
                default: if (sw_clear) begin m_st = 2; m_m = 0; end
            endcase
            if (m_fail) begin
                m_sel = FB_SRC; m_flag = 1; m_trap = 1;
            end else begin
                if (m_acc) m_sel = sw_target;
                if (sw_clear) begin m_flag = 0; m_trap = 0; end
                if (!watch_en) m_trap = 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One reference cycle: compare with the model, then move the clock pattern.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk({cur_req, " model clk_sel"}, clk_sel, m_sel);
        chk({cur_req, " model fail_flag"}, fail_flag, m_flag);
        chk({cur_req, " model trap_req"}, trap_req, m_trap);
        if (mon_period == 0) begin
            mon_clk = 1'b0;
            mon_phase = 0;
        end else begin
            mon_clk = (mon_phase == 0);
            mon_phase = (mon_phase + 1) % mon_period;
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        watch_en = 1'b1;
        steps(3);
        chk("R1 reset clk_sel", clk_sel, RST_SRC);
        chk("R1 reset fail_flag", fail_flag, 0);
        chk("R1 reset trap_req", trap_req, 0);
        rst_n = 1'b1;

        // R2 dead clock, no start pulse
        cur_req = "R2";
        steps(20);
        chk("R2 idle trap", trap_req, 0);

        // R4 boundary: period N never fails, period N+1 fails
        cur_req = "R4";
        mon_period = N;
        steps(6);
        src_slow = 1'b0; seq_start = 1'b1; step(); seq_start = 1'b0;
        steps(40);
        chk("R4 period N no trap", trap_req, 0);
        mon_period = N + 1;
        steps(30);
        chk("R4 period N+1 trap", trap_req, 1);
        chk("R4 fallback select", clk_sel, FB_SRC);
        chk("R4 flag set", fail_flag, 1);

        // R6 refused switch while trap pending
        cur_req = "R6";
        mon_period = 2;
        sw_target = 3'd5; sw_req = 1'b1; step(); sw_req = 1'b0;
        chk("R6 select unchanged", clk_sel, FB_SRC);

        // R5 sticky until clear
        cur_req = "R5";
        steps(10);
        chk("R5 flag sticky", fail_flag, 1);
        chk("R5 trap sticky", trap_req, 1);
        sw_clear = 1'b1; step(); sw_clear = 1'b0;
        chk("R5 flag cleared", fail_flag, 0);
        chk("R5 trap cleared", trap_req, 0);
        steps(20);
        chk("R5 watching running clock", trap_req, 0);

        // R7 accepted fast switch
        cur_req = "R7";
        src_slow = 1'b0; sw_target = 3'd5; sw_req = 1'b1; step(); sw_req = 1'b0;
        chk("R7 switch applied", clk_sel, 5);
        steps(10);

        // R3 slow switch onto a dead clock
        cur_req = "R3";
        mon_period = 0; src_slow = 1'b1; sw_target = 3'd2; sw_req = 1'b1;
        step(); sw_req = 1'b0;
        chk("R7 slow switch applied", clk_sel, 2);
        steps(11);
        chk("R3 no trap before guard plus limit", trap_req, 0);
        step();
        chk("R3 trap at guard plus limit", trap_req, 1);

        // R10 running clock that stops
        cur_req = "R10";
        mon_period = 3; src_slow = 1'b0;
        sw_clear = 1'b1; step(); sw_clear = 1'b0;
        steps(20);
        chk("R10 running no trap", trap_req, 0);
        mon_period = 0;
        steps(10);
        chk("R10 stopped clock trap", trap_req, 1);

        // R8 disabled behaviour
        cur_req = "R8";
        watch_en = 1'b0; step();
        chk("R8 trap dropped", trap_req, 0);
        chk("R8 flag kept", fail_flag, 1);
        steps(30);
        chk("R8 select held", clk_sel, FB_SRC);
        sw_target = 3'd6; sw_req = 1'b1; step(); sw_req = 1'b0;
        chk("R8 switch honoured", clk_sel, 6);
        sw_clear = 1'b1; step(); sw_clear = 1'b0;
        chk("R8 flag cleared", fail_flag, 0);

        // R9 re-enable needs a new start
        cur_req = "R9";
        watch_en = 1'b1; src_slow = 1'b0;
        steps(20);
        chk("R9 no watch without start", trap_req, 0);
        seq_start = 1'b1; step(); seq_start = 1'b0;
        steps(3);
        chk("R9 no trap before limit", trap_req, 0);
        step();
        chk("R9 trap after fast start", trap_req, 1);
        steps(4);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule